// File: doc/BRIEF.md
# PLL Clock-Fault Reset Supervisor

This block sits beside a phase-locked loop and reports two faults: the loop losing lock, and one of the two phase-detector inputs (the reference clock or the feedback clock) running too slowly or stopping. Each fault has its own reset enable. Lock loss also has an interrupt enable, and the clock monitor has a master enable. Live and sticky status flags show the faults to software. The interrupt request is a level that stays high until software clears the sticky lock-loss flag.

When the block raises its reset request, the live and sticky lock and clock flags are wiped. A separate cause register records which fault caused the reset. Only power-on reset clears this register, so software can read the reason after the restart. In external clock mode the loop is bypassed, and every fault path is silenced.

Clock presence is measured with a fast monitor clock. Each monitored clock passes through a two-flop synchroniser. Its rising edges are then counted over a fixed window of monitor cycles, and a window with too few edges marks that clock as lost.

Top module: `pllFaultSupervisor`

## Requirements
- R1: After power-on reset, every status flag, both cause bits, `irqReq` and `resetReq` are 0.
- R2: In PLL mode, with `ctrlLolReset` high, a lock drop seen while `lockFlag` is 1 raises `resetReq` on the next clock and sets `causeLol`.
- R3: While `resetReq` is high, the flags `lockFlag`, `lolSticky`, `locFlag` and `locSticky` read 0 from the next clock on, even if `pllLock` is high.
- R4: A lock drop sets `lolSticky`. With `ctrlLolIrq` high, `irqReq` follows `lolSticky` as a level and falls only after a one-cycle pulse on `clrStickyLock`.
- R5: With `ctrlClkMonEn` high, the monitor judges each window of `WIN_CYCLES` clocks. A window with fewer than `MIN_EDGES` rising edges on either clock sets `locFlag` and `locSticky`. A later good window clears `locFlag` but leaves `locSticky` set.
- R6: With `ctrlLocReset` and `ctrlClkMonEn` high, a clock-loss judgement raises `resetReq` and sets `causeLoc`.
- R7: With `extClkMode` high, no fault sets a flag or a cause bit, `irqReq` stays 0, and `resetReq` is 0 from the next clock on, whatever the enables.
- R8: Once raised in PLL mode, `resetReq` falls only at a window judgement in which the reference clock had at least `MIN_EDGES` edges and `pllLock` is high.
- R9: While `stopPllOff` is high, a lock drop is ignored. After stop ends and lock returns, `lolSticky` keeps its value from before stop.
- R10: One-cycle pulses on `clrStickyLock`, `clrStickyClk`, `clrCauseLol` and `clrCauseLoc` clear the matching bit. The cause bits survive `resetReq` and are otherwise cleared only by `porRstN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast monitor clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| ctrlLolReset | input | 1 | Reset on lock loss enable |
| ctrlLolIrq | input | 1 | Interrupt on lock loss enable |
| ctrlClkMonEn | input | 1 | Clock-loss monitor enable |
| ctrlLocReset | input | 1 | Reset on clock loss enable |
| extClkMode | input | 1 | 1 = external clock mode, 0 = PLL mode |
| stopPllOff | input | 1 | Stop mode with the PLL switched off |
| pllLock | input | 1 | Lock indication from the PLL |
| refClkIn | input | 1 | Reference clock to be monitored |
| fbClkIn | input | 1 | Feedback clock to be monitored |
| clrStickyLock | input | 1 | Write-one-to-clear pulse for lolSticky |
| clrStickyClk | input | 1 | Write-one-to-clear pulse for locSticky |
| clrCauseLol | input | 1 | Write-one-to-clear pulse for causeLol |
| clrCauseLoc | input | 1 | Write-one-to-clear pulse for causeLoc |
| lockFlag | output | 1 | Live lock status |
| lolSticky | output | 1 | Sticky lock-loss flag |
| locFlag | output | 1 | Live clock-loss flag, updated each window |
| locSticky | output | 1 | Sticky clock-loss flag |
| causeLol | output | 1 | Reset cause: lock loss |
| causeLoc | output | 1 | Reset cause: clock loss |
| irqReq | output | 1 | Level interrupt request for lock loss |
| resetReq | output | 1 | System reset request |

## Verification
The bench first stops the reference clock, then brings lock back while the reference is still stopped. A supervisor that released on lock alone would drop `resetReq` too early. It then restarts the reference, and a design that never rechecked presence would keep the request high forever.

A slow feedback clock, not just a stopped one, checks the edge threshold; a design that only looked for a stuck level would miss it. Lock is dropped during stop mode, so a design that did not mask stop would set the sticky flag.

In external clock mode the bench stops both clocks and drops lock with every enable set; any leak shows up as a flag, an interrupt or a reset. The cause bits are read after a self-generated reset, which would have erased them if they shared the status reset.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int NUM_MON = 2;   // index 0: reference, index 1: feedback
  localparam int REF_IDX = 0;
  localparam int FB_IDX  = 1;

  typedef struct packed {
    logic run;                  // monitor windows active (PLL mode)
  } monCtl_t;

  typedef struct packed {
    logic judged;               // one-cycle strobe: a window just closed
    logic lostRef;              // reference had too few edges
    logic lostFb;               // feedback had too few edges
  } monStat_t;
endpackage

// File: rtl/pfsClockMonitor.sv
module pfsClockMonitor
  import pfs_pkg::*;
#(
  parameter int WIN_CYCLES  = 32,
  parameter int MIN_EDGES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               porRstN,
  input  monCtl_t            ctl,
  input  logic [NUM_MON-1:0] clkIn,
  output monStat_t           stat
);
  localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

  logic [WIN_W-1:0]   winCnt;
  logic               winEnd;
  logic [NUM_MON-1:0] rise;
  logic [NUM_MON-1:0] lost;
  logic               judged;

  assign winEnd = ctl.run && (winCnt == WIN_LAST);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      winCnt <= '0;
      judged <= 1'b0;
    end else if (!ctl.run) begin
      winCnt <= '0;
      judged <= 1'b0;
    end else begin
      winCnt <= winEnd ? '0 : winCnt + 1'b1;
      judged <= winEnd;
    end
  end

  for (genvar g = 0; g < NUM_MON; g++) begin : g_chan
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   lastQ;
    logic [CNT_W-1:0]       edgeCnt;

    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN) begin
        syncQ <= '0;
        lastQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], clkIn[g]};
        lastQ <= syncQ[SYNC_STAGES-1];
      end
    end

    assign rise[g] = syncQ[SYNC_STAGES-1] && !lastQ;

    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN) begin
        edgeCnt <= '0;
        lost[g] <= 1'b0;
      end else if (!ctl.run) begin
        edgeCnt <= '0;
        lost[g] <= 1'b0;
      end else if (winEnd) begin
        edgeCnt <= '0;
        lost[g] <= (32'(edgeCnt) < MIN_EDGES);
      end else begin
        edgeCnt <= edgeCnt + CNT_W'(rise[g]);
      end
    end
  end

  assign stat.judged  = judged;
  assign stat.lostRef = lost[REF_IDX];
  assign stat.lostFb  = lost[FB_IDX];
endmodule

// File: rtl/pfsControl.sv
module pfsControl
  import pfs_pkg::*;
(
  input  logic     clk,
  input  logic     porRstN,
  input  logic     ctrlLolReset,
  input  logic     ctrlLolIrq,
  input  logic     ctrlClkMonEn,
  input  logic     ctrlLocReset,
  input  logic     extClkMode,
  input  logic     stopPllOff,
  input  logic     pllLock,
  input  logic     clrStickyLock,
  input  logic     clrStickyClk,
  input  logic     clrCauseLol,
  input  logic     clrCauseLoc,
  input  monStat_t stat,
  output monCtl_t  ctl,
  output logic     lockFlag,
  output logic     lolSticky,
  output logic     locFlag,
  output logic     locSticky,
  output logic     causeLol,
  output logic     causeLoc,
  output logic     irqReq,
  output logic     resetReq
);
  logic monOn, lolEvent, locEvent, rstTrigger, rstRelease;

  assign ctl.run    = !extClkMode;
  assign monOn      = ctrlClkMonEn && !extClkMode;
  assign lolEvent   = !extClkMode && !stopPllOff && !resetReq && lockFlag && !pllLock;
  assign locEvent   = monOn && !resetReq && stat.judged && (stat.lostRef || stat.lostFb);
  assign rstTrigger = (lolEvent && ctrlLolReset) || (locEvent && ctrlLocReset);
  assign rstRelease = extClkMode || (stat.judged && !stat.lostRef && pllLock);
  assign irqReq     = lolSticky && ctrlLolIrq && !extClkMode;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      lockFlag  <= 1'b0;
      lolSticky <= 1'b0;
      locFlag   <= 1'b0;
      locSticky <= 1'b0;
      resetReq  <= 1'b0;
    end else begin
      lockFlag <= !resetReq && !extClkMode && pllLock;

      if (!resetReq)      resetReq <= rstTrigger;
      else if (rstRelease) resetReq <= 1'b0;

      if (resetReq)           lolSticky <= 1'b0;
      else if (lolEvent)      lolSticky <= 1'b1;
      else if (clrStickyLock) lolSticky <= 1'b0;

      if (resetReq || !monOn) locFlag <= 1'b0;
      else if (stat.judged)   locFlag <= stat.lostRef || stat.lostFb;

      if (resetReq)          locSticky <= 1'b0;
      else if (locEvent)     locSticky <= 1'b1;
      else if (clrStickyClk) locSticky <= 1'b0;
    end
  end

  // Cause bits: cleared only by power-on reset or software.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      causeLol <= 1'b0;
      causeLoc <= 1'b0;
    end else begin
      if (lolEvent && ctrlLolReset) causeLol <= 1'b1;
      else if (clrCauseLol)         causeLol <= 1'b0;
      if (locEvent && ctrlLocReset) causeLoc <= 1'b1;
      else if (clrCauseLoc)         causeLoc <= 1'b0;
    end
  end
endmodule

// File: rtl/pllFaultSupervisor.sv
module pllFaultSupervisor
  import pfs_pkg::*;
#(
  parameter int WIN_CYCLES  = 32,
  parameter int MIN_EDGES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic porRstN,
  input  logic ctrlLolReset,
  input  logic ctrlLolIrq,
  input  logic ctrlClkMonEn,
  input  logic ctrlLocReset,
  input  logic extClkMode,
  input  logic stopPllOff,
  input  logic pllLock,
  input  logic refClkIn,
  input  logic fbClkIn,
  input  logic clrStickyLock,
  input  logic clrStickyClk,
  input  logic clrCauseLol,
  input  logic clrCauseLoc,
  output logic lockFlag,
  output logic lolSticky,
  output logic locFlag,
  output logic locSticky,
  output logic causeLol,
  output logic causeLoc,
  output logic irqReq,
  output logic resetReq
);
  monCtl_t  monCtl;
  monStat_t monStat;

  pfsClockMonitor #(
    .WIN_CYCLES (WIN_CYCLES),
    .MIN_EDGES  (MIN_EDGES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_monitor (
    .clk    (clk),
    .porRstN(porRstN),
    .ctl    (monCtl),
    .clkIn  ({fbClkIn, refClkIn}),
    .stat   (monStat)
  );

  pfsControl u_control (
    .clk          (clk),
    .porRstN      (porRstN),
    .ctrlLolReset (ctrlLolReset),
    .ctrlLolIrq   (ctrlLolIrq),
    .ctrlClkMonEn (ctrlClkMonEn),
    .ctrlLocReset (ctrlLocReset),
    .extClkMode   (extClkMode),
    .stopPllOff   (stopPllOff),
    .pllLock      (pllLock),
    .clrStickyLock(clrStickyLock),
    .clrStickyClk (clrStickyClk),
    .clrCauseLol  (clrCauseLol),
    .clrCauseLoc  (clrCauseLoc),
    .stat         (monStat),
    .ctl          (monCtl),
    .lockFlag     (lockFlag),
    .lolSticky    (lolSticky),
    .locFlag      (locFlag),
    .locSticky    (locSticky),
    .causeLol     (causeLol),
    .causeLoc     (causeLoc),
    .irqReq       (irqReq),
    .resetReq     (resetReq)
  );
endmodule

// File: rtl/pllFaultSupervisor_checker.sv
module pllFaultSupervisor_checker (
  input logic clk,
  input logic porRstN,
  input logic ctrlLolReset,
  input logic extClkMode,
  input logic stopPllOff,
  input logic pllLock,
  input logic clrCauseLol,
  input logic lockFlag,
  input logic lolSticky,
  input logic locSticky,
  input logic causeLol,
  input logic irqReq,
  input logic resetReq
);
  p_lol_reset_r2: assert property (@(posedge clk) disable iff (!porRstN)
    (!extClkMode && !stopPllOff && !resetReq && lockFlag && !pllLock && ctrlLolReset)
      |=> (resetReq && causeLol));

  p_flags_wiped_r3: assert property (@(posedge clk) disable iff (!porRstN)
    resetReq |=> (!lolSticky && !locSticky && !lockFlag));

  p_ext_no_reset_r7: assert property (@(posedge clk) disable iff (!porRstN)
    extClkMode |=> !resetReq);

  p_ext_no_irq_r7: assert property (@(posedge clk) disable iff (!porRstN)
    extClkMode |-> !irqReq);

  p_hold_unlocked_r8: assert property (@(posedge clk) disable iff (!porRstN)
    (resetReq && !pllLock && !extClkMode) |=> resetReq);

  p_stop_masks_r9: assert property (@(posedge clk) disable iff (!porRstN)
    (stopPllOff && !lolSticky) |=> !lolSticky);

  p_cause_kept_r10: assert property (@(posedge clk) disable iff (!porRstN)
    (causeLol && !clrCauseLol) |=> causeLol);
endmodule

bind pllFaultSupervisor pllFaultSupervisor_checker u_checker (
  .clk         (clk),
  .porRstN     (porRstN),
  .ctrlLolReset(ctrlLolReset),
  .extClkMode  (extClkMode),
  .stopPllOff  (stopPllOff),
  .pllLock     (pllLock),
  .clrCauseLol (clrCauseLol),
  .lockFlag    (lockFlag),
  .lolSticky   (lolSticky),
  .locSticky   (locSticky),
  .causeLol    (causeLol),
  .irqReq      (irqReq),
  .resetReq    (resetReq)
);

// File: tb/pllFaultSupervisor_bench.sv
`timescale 1ns/1ps
module pllFaultSupervisor_bench;
  localparam int WIN = 32;
  localparam int MINE = 4;

  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic ctrlLolReset = 0, ctrlLolIrq = 0, ctrlClkMonEn = 0, ctrlLocReset = 0;
  logic extClkMode = 0, stopPllOff = 0, pllLock = 0;
  logic refClkIn = 0, fbClkIn = 0;
  logic clrStickyLock = 0, clrStickyClk = 0, clrCauseLol = 0, clrCauseLoc = 0;
  logic lockFlag, lolSticky, locFlag, locSticky, causeLol, causeLoc, irqReq, resetReq;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  int refHalf = 0, fbHalf = 0, refTmr = 0, fbTmr = 0;

  always #4 clk = ~clk;

  pllFaultSupervisor #(.WIN_CYCLES(WIN), .MIN_EDGES(MINE)) u_pllFaultSupervisor (
    .clk(clk), .porRstN(porRstN),
    .ctrlLolReset(ctrlLolReset), .ctrlLolIrq(ctrlLolIrq),
    .ctrlClkMonEn(ctrlClkMonEn), .ctrlLocReset(ctrlLocReset),
    .extClkMode(extClkMode), .stopPllOff(stopPllOff), .pllLock(pllLock),
    .refClkIn(refClkIn), .fbClkIn(fbClkIn),
    .clrStickyLock(clrStickyLock), .clrStickyClk(clrStickyClk),
    .clrCauseLol(clrCauseLol), .clrCauseLoc(clrCauseLoc),
    .lockFlag(lockFlag), .lolSticky(lolSticky), .locFlag(locFlag),
    .locSticky(locSticky), .causeLol(causeLol), .causeLoc(causeLoc),
    .irqReq(irqReq), .resetReq(resetReq));

  // Monitored clocks: toggle every refHalf / fbHalf cycles, 0 = stopped.
  always @(negedge clk) begin
    if (refHalf != 0) begin
      if (refTmr + 1 >= refHalf) begin refTmr <= 0; refClkIn <= ~refClkIn; end
      else refTmr <= refTmr + 1;
    end
    if (fbHalf != 0) begin
      if (fbTmr + 1 >= fbHalf) begin fbTmr <= 0; fbClkIn <= ~fbClkIn; end
      else fbTmr <= fbTmr + 1;
    end
  end

  // Behavioural reference model, evaluated from the requirements.
  bit rH0, rH1, rH2, fH0, fH1, fH2;
  int winPos, refEdges, fbEdges;
  bit judgeNow, refLost, fbLost;
  bit mLock, mLolS, mLoc, mLocS, mCauseLol, mCauseLoc, mRst;
  bit evLol, evLoc, monOn;

  always @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      {rH0, rH1, rH2, fH0, fH1, fH2} <= '0;
      winPos <= 0; refEdges <= 0; fbEdges <= 0;
      judgeNow <= 0; refLost <= 0; fbLost <= 0;
      {mLock, mLolS, mLoc, mLocS, mCauseLol, mCauseLoc, mRst} <= '0;
    end else begin
      rH0 <= refClkIn; rH1 <= rH0; rH2 <= rH1;
      fH0 <= fbClkIn;  fH1 <= fH0; fH2 <= fH1;
      if (extClkMode) begin
        winPos <= 0; refEdges <= 0; fbEdges <= 0;
        judgeNow <= 0; refLost <= 0; fbLost <= 0;
      end else if (winPos == WIN - 1) begin
        winPos <= 0; refEdges <= 0; fbEdges <= 0; judgeNow <= 1;
        refLost <= refEdges < MINE; fbLost <= fbEdges < MINE;
      end else begin
        winPos <= winPos + 1; judgeNow <= 0;
        refEdges <= refEdges + int'(rH1 && !rH2);
        fbEdges  <= fbEdges + int'(fH1 && !fH2);
      end
      monOn = ctrlClkMonEn && !extClkMode;
      evLol = !extClkMode && !stopPllOff && !mRst && mLock && !pllLock;
      evLoc = monOn && !mRst && judgeNow && (refLost || fbLost);
      mLock <= !mRst && !extClkMode && pllLock;
      if (!mRst) mRst <= (evLol && ctrlLolReset) || (evLoc && ctrlLocReset);
      else if (extClkMode || (judgeNow && !refLost && pllLock)) mRst <= 0;
      mLolS <= mRst ? 0 : evLol ? 1 : clrStickyLock ? 0 : mLolS;
      mLoc  <= (mRst || !monOn) ? 0 : judgeNow ? (refLost || fbLost) : mLoc;
      mLocS <= mRst ? 0 : evLoc ? 1 : clrStickyClk ? 0 : mLocS;
      mCauseLol <= (evLol && ctrlLolReset) ? 1 : clrCauseLol ? 0 : mCauseLol;
      mCauseLoc <= (evLoc && ctrlLocReset) ? 1 : clrCauseLoc ? 0 : mCauseLoc;
    end
  end

  task automatic cmp(input bit act, input bit exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    #1;
    if (porRstN && !done) begin
      cmp(lockFlag,  mLock,     "R3", "lockFlag model");
      cmp(lolSticky, mLolS,     "R4", "lolSticky model");
      cmp(locFlag,   mLoc,      "R5", "locFlag model");
      cmp(locSticky, mLocS,     "R5", "locSticky model");
      cmp(causeLol,  mCauseLol, "R2", "causeLol model");
      cmp(causeLoc,  mCauseLoc, "R6", "causeLoc model");
      cmp(irqReq,    mLolS && ctrlLolIrq && !extClkMode, "R4", "irqReq model");
      cmp(resetReq,  mRst,      "R8", "resetReq model");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    #1;
    cmp(act, exp, tag, what);
  endtask

  task automatic pulse(ref logic sig);
    tick(1); sig = 1; tick(1); sig = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    porRstN = 1;
    tick(1);
    chk(resetReq, 0, "R1", "resetReq after POR");
    chk(lolSticky, 0, "R1", "lolSticky after POR");
    chk(causeLol || causeLoc, 0, "R1", "cause after POR");

    pllLock = 1; refHalf = 2; fbHalf = 2;
    tick(100);
    chk(lockFlag, 1, "R3", "lockFlag tracks lock");
    chk(locFlag, 0, "R5", "no loss with fast clocks");

    // R9: lock drop during stop with PLL off is ignored
    stopPllOff = 1; pllLock = 0; tick(5);
    pllLock = 1; tick(3); stopPllOff = 0; tick(3);
    chk(lolSticky, 0, "R9", "sticky kept across stop");
    chk(resetReq, 0, "R9", "no reset from stop");

    // R4: interrupt level until cleared
    ctrlLolIrq = 1; pllLock = 0; tick(1); pllLock = 1; tick(1);
    chk(irqReq, 1, "R4", "irq raised");
    tick(6);
    chk(irqReq, 1, "R4", "irq held as level");
    pulse(clrStickyLock); tick(1);
    chk(irqReq, 0, "R4", "irq cleared by W1C");
    ctrlLolIrq = 0;

    // R2, R3, R8: lock-loss reset, release needs lock and reference
    ctrlLolReset = 1; pllLock = 0; refHalf = 0; tick(1);
    chk(resetReq, 1, "R2", "reset on lock loss");
    chk(causeLol, 1, "R2", "causeLol set");
    tick(45); pllLock = 1; tick(5);
    chk(lockFlag, 0, "R3", "lockFlag wiped in reset");
    tick(75);
    chk(resetReq, 1, "R8", "held while reference stopped");
    refHalf = 2; tick(80);
    chk(resetReq, 0, "R8", "released after reference returns");
    chk(causeLol, 1, "R10", "causeLol survives self reset");
    pulse(clrCauseLol); tick(1);
    chk(causeLol, 0, "R10", "causeLol W1C");
    ctrlLolReset = 0;

    // R5: stopped then slow feedback clock
    ctrlClkMonEn = 1; fbHalf = 0; tick(80);
    chk(locFlag, 1, "R5", "locFlag on stopped feedback");
    chk(locSticky, 1, "R5", "locSticky set");
    chk(resetReq, 0, "R5", "no reset without enable");
    fbHalf = 2; tick(80);
    chk(locFlag, 0, "R5", "locFlag clears");
    chk(locSticky, 1, "R5", "locSticky stays");
    pulse(clrStickyClk); tick(1);
    chk(locSticky, 0, "R10", "locSticky W1C");
    fbHalf = 12; tick(80);
    chk(locFlag, 1, "R5", "slow feedback is lost");
    fbHalf = 2; tick(80); pulse(clrStickyClk);

    // R6: clock-loss reset
    ctrlLocReset = 1; refHalf = 0; tick(80);
    chk(resetReq, 1, "R6", "reset on clock loss");
    chk(causeLoc, 1, "R6", "causeLoc set");
    chk(locSticky, 0, "R3", "locSticky wiped in reset");
    refHalf = 2; tick(80);
    chk(resetReq, 0, "R8", "released after clock returns");
    ctrlLocReset = 0; pulse(clrCauseLoc); tick(1);
    chk(causeLoc, 0, "R10", "causeLoc W1C");

    // R7: external clock mode silences everything
    extClkMode = 1; ctrlLolReset = 1; ctrlLolIrq = 1; ctrlLocReset = 1;
    tick(2); refHalf = 0; fbHalf = 0; pllLock = 0; tick(80);
    chk(resetReq, 0, "R7", "no reset in external mode");
    chk(irqReq, 0, "R7", "no irq in external mode");
    chk(locFlag || locSticky || lolSticky, 0, "R7", "no flags in external mode");
    chk(causeLol || causeLoc, 0, "R7", "no cause in external mode");

    // R10: POR clears cause bits
    extClkMode = 0; refHalf = 2; fbHalf = 2; pllLock = 1; ctrlLolIrq = 0;
    ctrlLocReset = 0; tick(10);
    pllLock = 0; tick(1);
    chk(causeLol, 1, "R2", "causeLol set again");
    pllLock = 1; porRstN = 0; tick(2);
    chk(causeLol, 0, "R10", "POR clears cause");
    chk(resetReq, 0, "R1", "POR clears reset request");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule